// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is a host-side sequencer that erases NAND flash blocks over the device's 8-bit command/address bus. A request carries one to four row addresses, one for each plane. For each address the block sends the erase-setup command followed by three address bytes. It then sends a single confirm command, which starts the internal erase in the flash. While it does this, the sequencer drives the chip-enable, command-latch, address-latch, write-strobe and read-strobe pins. All pulse widths are counted in system clocks and set by parameters.

After the confirm command, the block waits a fixed settling time and then watches the ready/busy input. When the flash is ready, the block issues the status command and performs one read cycle. Bit 0 of the returned byte decides pass or fail. A run-time limit on the busy period guards against a flash that never becomes ready. Each request ends with a one-cycle done pulse, which carries a fail flag and a timeout flag.

Top module: `nand_erase_seq`

## Requirements
- R1: After reset, chip enable, write strobe and read strobe are high (inactive), CLE and ALE are low, `req_ready` is high and `done` is low.
- R2: A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the done pulse has been given.
- R3: Every byte is latched on a rising edge of `nf_we_n`. Command bytes have CLE=1 and ALE=0, and address bytes have CLE=0 and ALE=1. A single-block erase sends 60h, then the row address low byte first (bits 7:0, 15:8, 23:16), then D0h.
- R4: `req_nblk` encodes the number of blocks minus one (0 to 3). Slot g of `req_row` is bits [24g+23:24g]. The 60h-plus-three-address group is sent for slots 0 through `req_nblk` in ascending order, followed by exactly one D0h.
- R5: Each write cycle holds `nf_we_n` low for P_WL clocks and then high for P_WH clocks. `nf_dq` does not change while `nf_we_n` is low.
- R6: After D0h, the block waits P_WB clocks and then waits for `nf_rb` high. Once `nf_rb` is high it sends the status command 70h.
- R7: After 70h the block performs exactly one read cycle, with `nf_re_n` low for P_RL clocks and the output driver off. `nf_io0` sampled at the end of that low phase is reported on `done_fail` (0 = pass, 1 = erase error).
- R8: If `nf_rb` stays low for more than `busy_limit` clocks after the settling wait, the block ends the request with `done_fail`=1 and `done_tmo`=1. In that case no status command and no read cycle take place.
- R9: Chip enable is low for every write and read strobe of a request and is high again in the done cycle.
- R10: `done` is a single-cycle pulse per request. `done_tmo` is 0 whenever the status was actually read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| req_nblk | input | 2 | Number of blocks minus one |
| req_row | input | 96 | Four 24-bit row addresses, slot 0 in the low bits |
| busy_limit | input | BLW | Maximum busy clocks before timeout |
| done | output | 1 | One-cycle completion pulse |
| done_fail | output | 1 | Erase failed or timed out (valid with done) |
| done_tmo | output | 1 | Busy timeout occurred (valid with done) |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_oe | output | 1 | Output enable for the data bus driver |
| nf_dq | output | 8 | Command/address byte to the flash |
| nf_rb | input | 1 | Flash ready (1) / busy (0) |
| nf_io0 | input | 1 | Status bit 0 from the flash data bus |

## Verification
The bench compares every latched byte against the expected stream: the group count, the slot order, the byte order within an address and the single confirm. A design that dropped or repeated a plane group, swapped address bytes or sent a confirm after each group would put the wrong byte in some queue slot. It checks both polarities of the status bit, and it runs a busy period far past the limit and one well inside it. A design with an inverted pass/fail bit, a missing timeout or a timeout that fires on a normal erase would report the wrong flags. A status read issued after a timeout would show up as an extra byte in the stream. Strobe-width and chip-enable monitors catch write pulses of the wrong length and strobes given while the chip is deselected.

// File: rtl/nand_erase_seq.sv
module nand_erase_seq #(
  parameter int P_WL = 3,
  parameter int P_WH = 2,
  parameter int P_WB = 4,
  parameter int P_RL = 3,
  parameter int P_RH = 2,
  parameter int BLW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [1:0]     req_nblk,
  input  logic [95:0]    req_row,
  input  logic [BLW-1:0] busy_limit,
  output logic           done,
  output logic           done_fail,
  output logic           done_tmo,
  output logic           nf_ce_n,
  output logic           nf_cle,
  output logic           nf_ale,
  output logic           nf_we_n,
  output logic           nf_re_n,
  output logic           nf_dq_oe,
  output logic [7:0]     nf_dq,
  input  logic           nf_rb,
  input  logic           nf_io0
);
  localparam int M1   = (P_WL > P_WH) ? P_WL : P_WH;
  localparam int M2   = (P_WB > P_RL) ? P_WB : P_RL;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int PMAX = (M3 > P_RH) ? M3 : P_RH;
  localparam int CW   = $clog2(PMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WLO, S_WHI, S_WB, S_BUSY, S_RLO, S_RHI, S_FIN} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [BLW-1:0] bcnt;
  logic [4:0]     idx;
  logic [1:0]     n_q;
  logic [95:0]    row_q;
  logic           stat_q, fail_q, tmo_q;

  wire [4:0] last   = {1'b0, n_q, 2'b00} + 5'd4;
  wire       at_cfm = (idx == last);
  wire [1:0] byt    = idx[1:0];
  wire [6:0] ofs    = (byt == 2'd0) ? 7'd0 : 7'(idx[3:2]) * 7'd24 + (7'(byt) - 7'd1) * 7'd8;
  wire       is_cmd = stat_q || at_cfm || (byt == 2'd0);
  wire       wr     = (st == S_WLO) || (st == S_WHI);

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign done_fail = fail_q;
  assign done_tmo  = tmo_q;
  assign nf_ce_n   = (st == S_IDLE) || (st == S_FIN);
  assign nf_cle    = wr && is_cmd;
  assign nf_ale    = wr && !is_cmd;
  assign nf_we_n   = (st != S_WLO);
  assign nf_re_n   = (st != S_RLO);
  assign nf_dq_oe  = wr;
  assign nf_dq     = stat_q ? 8'h70 : at_cfm ? 8'hD0 : (byt == 2'd0) ? 8'h60 : row_q[ofs +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bcnt <= '0; idx <= '0; n_q <= '0;
      row_q <= '0; stat_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          n_q <= req_nblk; row_q <= req_row; idx <= '0; cnt <= '0;
          stat_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0; st <= S_WLO;
        end
        S_WLO: if (cnt == CW'(P_WL - 1)) begin cnt <= '0; st <= S_WHI; end
               else cnt <= cnt + 1'b1;
        S_WHI: if (cnt == CW'(P_WH - 1)) begin
          cnt <= '0;
          if (stat_q)      st <= S_RLO;
          else if (at_cfm) st <= S_WB;
          else begin idx <= idx + 5'd1; st <= S_WLO; end
        end else cnt <= cnt + 1'b1;
        S_WB: if (cnt == CW'(P_WB - 1)) begin cnt <= '0; bcnt <= '0; st <= S_BUSY; end
              else cnt <= cnt + 1'b1;
        S_BUSY: if (nf_rb) begin stat_q <= 1'b1; st <= S_WLO; end
                else if (bcnt == busy_limit) begin fail_q <= 1'b1; tmo_q <= 1'b1; st <= S_FIN; end
                else bcnt <= bcnt + 1'b1;
        S_RLO: if (cnt == CW'(P_RL - 1)) begin cnt <= '0; fail_q <= nf_io0; st <= S_RHI; end
               else cnt <= cnt + 1'b1;
        S_RHI: if (cnt == CW'(P_RH - 1)) begin cnt <= '0; st <= S_FIN; end
               else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R3
  strobe_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (nf_cle ^ nf_ale) && !nf_ce_n);
  // R5
  dq_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_we_n |=> $stable(nf_dq));
  // R7
  read_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_re_n |-> !nf_dq_oe && !nf_ce_n && nf_we_n);
  // R8
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_tmo |-> done_fail);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/nand_erase_seq_bench.sv
module nand_erase_seq_bench;
  localparam int P_WL = 3, P_WH = 2, P_WB = 4, P_RL = 3, P_RH = 2, BLW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_nblk = '0;
  logic [95:0] req_row = '0;
  logic [BLW-1:0] busy_limit = 16'd100;
  logic done, done_fail, done_tmo;
  logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] nf_dq;
  logic nf_rb = 1'b1, nf_io0 = 1'b0;

  int total = 0, bad = 0;
  int cur_busy = 10;
  int lo_run = 0, w_bad = 0, ce_bad = 0, re_falls = 0;
  logic [9:0] expq[$];
  event busy_ev;

  always #5 clk = ~clk;

  nand_erase_seq #(.P_WL(P_WL), .P_WH(P_WH), .P_WB(P_WB), .P_RL(P_RL), .P_RH(P_RH), .BLW(BLW)) u_nand_erase_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_nblk(req_nblk), .req_row(req_row), .busy_limit(busy_limit),
    .done(done), .done_fail(done_fail), .done_tmo(done_tmo),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_oe(nf_dq_oe), .nf_dq(nf_dq), .nf_rb(nf_rb), .nf_io0(nf_io0));

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each latched byte
  always @(posedge nf_we_n) if (rst_n === 1'b1) begin
    logic [9:0] got;
    #1;
    got = {nf_cle, nf_ale, nf_dq};
    if (expq.size() == 0) chk(1'b0, "R3 unexpected byte", int'(got), 0);
    else begin
      logic [9:0] e;
      e = expq.pop_front();
      chk(got == e, "R3/R4 byte stream", int'(got), int'(e));
    end
    if (got == {2'b10, 8'hD0}) -> busy_ev;
  end

  // flash busy model
  always begin
    @(busy_ev);
    @(negedge clk) nf_rb = 1'b0;
    repeat (cur_busy) @(negedge clk);
    nf_rb = 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (!nf_we_n) lo_run++;
    else begin
      if (lo_run != 0 && lo_run != P_WL) w_bad++;
      lo_run = 0;
    end
  end

  always @(negedge nf_we_n) if (rst_n && nf_ce_n) ce_bad++;
  always @(negedge nf_re_n) if (rst_n) begin
    re_falls++;
    if (nf_ce_n) ce_bad++;
  end

  task automatic run_op(input logic [1:0] nb, input logic [95:0] rows, input int blen,
                        input bit st, input bit exp_f, input bit exp_t, input logic [BLW-1:0] lim);
    int guard;
    for (int g = 0; g <= int'(nb); g++) begin
      expq.push_back({2'b10, 8'h60});
      for (int k = 0; k < 3; k++) expq.push_back({2'b01, rows[g*24 + k*8 +: 8]});
    end
    expq.push_back({2'b10, 8'hD0});
    if (!exp_t) expq.push_back({2'b10, 8'h70});
    while (nf_rb !== 1'b1) @(negedge clk);
    @(negedge clk);
    cur_busy = blen; nf_io0 = st; busy_limit = lim; re_falls = 0;
    req_nblk = nb; req_row = rows; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready drops after accept", int'(req_ready), 0);
    guard = 0;
    while (done !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    chk(done === 1'b1, "R10 done seen", int'(done), 1);
    chk(done_fail == exp_f, exp_t ? "R8 fail on timeout" : "R7 status fail flag", int'(done_fail), int'(exp_f));
    chk(done_tmo == exp_t, "R8/R10 timeout flag", int'(done_tmo), int'(exp_t));
    chk(nf_ce_n == 1'b1, "R9 chip enable high at done", int'(nf_ce_n), 1);
    chk(re_falls == (exp_t ? 0 : 1), "R7/R8 read cycle count", re_falls, exp_t ? 0 : 1);
    chk(expq.size() == 0, "R4/R6 all bytes sent", expq.size(), 0);
    expq.delete();
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", int'(done), 0);
    chk(req_ready == 1'b1, "R2 ready after done", int'(req_ready), 1);
    chk(w_bad == 0, "R5 write low width", w_bad, 0);
    chk(ce_bad == 0, "R9 strobe while deselected", ce_bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(nf_ce_n && nf_we_n && nf_re_n, "R1 strobes idle", int'({nf_ce_n, nf_we_n, nf_re_n}), 7);
    chk(!nf_cle && !nf_ale, "R1 latch enables low", int'({nf_cle, nf_ale}), 0);
    chk(req_ready && !done, "R1 ready and no done", int'({req_ready, done}), 2);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_op(2'd0, 96'h0_000000_000000_12A5C3, 10, 1'b0, 1'b0, 1'b0, 16'd100);
    run_op(2'd0, 96'h0_000000_000000_0F1E2D, 12, 1'b1, 1'b1, 1'b0, 16'd100);
    run_op(2'd3, 96'h334455_A1B2C3_0A0B0C_778899, 15, 1'b0, 1'b0, 1'b0, 16'd100);
    run_op(2'd1, 96'h0_000000_FEDCBA_010203, 8, 1'b1, 1'b1, 1'b0, 16'd100);
    run_op(2'd0, 96'h0_000000_000000_400001, 200, 1'b0, 1'b1, 1'b1, 16'd20);
    run_op(2'd2, 96'h0_000000_C0FFEE_BEEF00, 20, 1'b0, 1'b0, 1'b0, 16'd30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule